// File: doc/BRIEF.md
# Image Sensor Frame Timing Generator

This block produces the readout timing of a rolling-row image sensor from a single master clock. A programmable divider turns the master clock into a pixel-rate enable. Counters run at that rate to produce a line strobe during the active pixels of each row and a frame strobe that wraps the active rows. A one-cycle start-of-frame pulse, a per-pixel valid qualifier and row and column indices are also produced for the downstream pixel path.

Each frame opens with its vertical blanking rows, which are followed by the active rows. Window height, window width, horizontal and vertical blanking, dark-column mode, integration row count and divider all arrive as plain input ports. They are copied into shadow registers only at the frame boundary, so a frame never mixes two settings. Every row carries a fixed horizontal overhead that depends on the dark-column mode. A long integration row count stretches the frame by adding rows to vertical blanking.

Top module: `sensor_frame_timer`

## Requirements
- R1: One pixel period lasts (div + 2) master clocks. `pixel_valid` is high for exactly one master clock per pixel, so inside a line consecutive pulses are (div + 2) master clocks apart.
- R2: Each frame holds (height + 1) line strobes. Each one is high for (width + 1) pixel periods.
- R3: Horizontal blanking is H = K + max(hblank, 9) pixel periods. K is 121 when `cfg_dark` bit 1 is 1, 113 when `cfg_dark` is 2'b01, and 107 when `cfg_dark` is 2'b00. Line strobes rise every (width + 1 + H) pixel periods, which is the row time R.
- R4: An hblank value below 9 produces the same timing as an hblank value of 9.
- R5: `frame_valid` rises 6 pixel periods before the first line strobe of a frame and falls 6 pixel periods after the last one. Its high time is (height + 1) x R - (H - 12) pixel periods.
- R6: `frame_start` is high for exactly one master clock, in the first cycle in which `frame_valid` is high.
- R7: With a short integration count, a frame lasts (height + vblank + 2) x R pixel periods. `frame_valid` is low for the remainder of that time.
- R8: When the integration count is at least (height + vblank + 2), the frame lasts (integration + 1) x R pixel periods instead. The added rows lengthen the low time of `frame_valid`.
- R9: Inputs are sampled only at the frame boundary, which is the start of vertical blanking. Changing them after `frame_start` leaves the rest of that frame's line and frame timing unchanged, and the following frame uses the new values.
- R10: At each `pixel_valid` pulse, `col_idx` equals the pixel index within the line, counting from 0, and `row_idx` equals the line index within the frame, counting from 0.
- R11: While `rst` is high, all strobes are low. After release, the frame restarts at the start of vertical blanking, so the first `frame_start` arrives ((blank rows) x R - 6) x (div + 2) master clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rows | input | GW | Window height minus one |
| cfg_cols | input | GW | Window width minus one |
| cfg_hblank | input | GW | Horizontal blanking addend (minimum 9) |
| cfg_vblank | input | GW | Vertical blanking rows minus one |
| cfg_dark | input | 2 | Dark-column mode selecting the row overhead |
| cfg_integ | input | IW | Integration row count |
| cfg_div | input | DW | Pixel divider; pixel period is cfg_div + 2 master clocks |
| pix_en | output | 1 | Pixel-rate enable, one master clock per pixel period |
| line_valid | output | 1 | High during the active pixels of a row |
| frame_valid | output | 1 | High around the active rows of a frame |
| frame_start | output | 1 | One-cycle pulse on the rise of frame_valid |
| pixel_valid | output | 1 | One pulse per active pixel |
| row_idx | output | GW | Active line index, zero outside lines |
| col_idx | output | GW | Active pixel index, zero outside lines |

## Verification
The bench measures every strobe duration in master clocks and compares it with the arithmetic formulas for all four dark-mode codes and for three divider values. A wrong overhead constant or a missing hblank clamp would shift every row period. An off-by-one in the 6-pixel margins would lengthen or shorten `frame_valid` by exactly (div + 2) cycles. The integration count is placed one row below, exactly at, and well above the stretch threshold, which exposes a comparison that uses > where >= is required. A swap of settings right after `frame_start` catches shadow registers that load at the wrong moment, because the current frame's line widths would change partway through.

// File: rtl/sensor_frame_timer.sv
module sensor_frame_timer #(
  parameter int GW       = 12,
  parameter int DW       = 6,
  parameter int IW       = 12,
  parameter int MARGIN   = 6,
  parameter int HB_MIN   = 9,
  parameter int K_NONE   = 107,
  parameter int K_NARROW = 113,
  parameter int K_WIDE   = 121
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [GW-1:0] cfg_rows,
  input  logic [GW-1:0] cfg_cols,
  input  logic [GW-1:0] cfg_hblank,
  input  logic [GW-1:0] cfg_vblank,
  input  logic [1:0]    cfg_dark,
  input  logic [IW-1:0] cfg_integ,
  input  logic [DW-1:0] cfg_div,
  output logic          pix_en,
  output logic          line_valid,
  output logic          frame_valid,
  output logic          frame_start,
  output logic          pixel_valid,
  output logic [GW-1:0] row_idx,
  output logic [GW-1:0] col_idx
);
  localparam int TW = GW + 2;

  logic [GW-1:0] rows_s, cols_s, hb_s, vb_s;
  logic [1:0]    dark_s;
  logic [IW-1:0] integ_s;
  logic [DW-1:0] div_s;

  logic [DW:0]   div_cnt;
  logic [TW-1:0] col_cnt, row_cnt;
  logic          fv_q;

  logic [TW-1:0] k_ovh, act_w, hb_eff, h_tot, row_len;
  logic [TW-1:0] base_rows, n_rows, n_blank;
  logic          long_int, last_col, last_row, frame_end;
  logic          in_active, lv_raw, lead, trail_off, fv_raw;

  assign k_ovh = dark_s[1] ? TW'(K_WIDE) : (dark_s[0] ? TW'(K_NARROW) : TW'(K_NONE));
  assign act_w = TW'(cols_s) + 1'b1;
  assign hb_eff = (TW'(hb_s) < TW'(HB_MIN)) ? TW'(HB_MIN) : TW'(hb_s);
  assign h_tot = k_ovh + hb_eff;
  assign row_len = act_w + h_tot;

  assign base_rows = TW'(rows_s) + TW'(vb_s) + TW'(2);
  assign long_int = TW'(integ_s) >= base_rows;
  assign n_rows = long_int ? TW'(integ_s) + 1'b1 : base_rows;
  assign n_blank = n_rows - TW'(rows_s) - 1'b1;

  assign pix_en = !rst && (div_cnt == {1'b0, div_s} + 1'b1);
  assign last_col = col_cnt == row_len - 1'b1;
  assign last_row = row_cnt == n_rows - 1'b1;
  assign frame_end = pix_en && last_col && last_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      col_cnt <= '0;
      row_cnt <= '0;
      fv_q    <= 1'b0;
    end else begin
      fv_q    <= frame_valid;
      div_cnt <= pix_en ? '0 : div_cnt + 1'b1;
      if (pix_en) begin
        if (last_col) begin
          col_cnt <= '0;
          row_cnt <= last_row ? '0 : row_cnt + 1'b1;
        end else begin
          col_cnt <= col_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || frame_end) begin
      rows_s  <= cfg_rows;
      cols_s  <= cfg_cols;
      hb_s    <= cfg_hblank;
      vb_s    <= cfg_vblank;
      dark_s  <= cfg_dark;
      integ_s <= cfg_integ;
      div_s   <= cfg_div;
    end
  end

  assign in_active = row_cnt >= n_blank;
  assign lv_raw    = in_active && (col_cnt < act_w);
  assign lead      = (row_cnt == n_blank - 1'b1) && (col_cnt >= row_len - TW'(MARGIN));
  assign trail_off = last_row && (col_cnt >= act_w + TW'(MARGIN));
  assign fv_raw    = lead || (in_active && !trail_off);

  assign line_valid  = !rst && lv_raw;
  assign frame_valid = !rst && fv_raw;
  assign frame_start = frame_valid && !fv_q;
  assign pixel_valid = line_valid && pix_en;
  assign row_idx     = line_valid ? GW'(row_cnt - n_blank) : '0;
  assign col_idx     = line_valid ? GW'(col_cnt) : '0;

  // R1
  pv_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    pixel_valid |=> !pixel_valid);

  // R1
  en_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_en && div_s != '0) |=> !pix_en);

  // R2
  lv_inside_fv_chk: assert property (@(posedge clk) disable iff (rst)
    line_valid |-> frame_valid);

  // R5
  fv_fall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_valid) |-> !line_valid);

  // R6
  sof_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  // R6
  sof_before_line_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> !line_valid);

  // R10
  col_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(line_valid) |-> col_idx == '0);
endmodule

// File: tb/sim_sensor_frame_timer.sv
`timescale 1ns/1ps
module sim_sensor_frame_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] h, w, hb, vb, integ;
  logic [1:0]  dk;
  logic [5:0]  dv;
  logic pix_en, lv, fv, fs, pv;
  logic [11:0] row_idx, col_idx;
  logic [11:0] n_h, n_w, n_hb, n_vb, n_integ;
  logic [1:0]  n_dk;
  logic [5:0]  n_dv;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sensor_frame_timer u0 (
    .clk(clk), .rst(rst), .cfg_rows(h), .cfg_cols(w), .cfg_hblank(hb),
    .cfg_vblank(vb), .cfg_dark(dk), .cfg_integ(integ), .cfg_div(dv),
    .pix_en(pix_en), .line_valid(lv), .frame_valid(fv), .frame_start(fs),
    .pixel_valid(pv), .row_idx(row_idx), .col_idx(col_idx));

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int kval(input int m);
    return (m >= 2) ? 121 : ((m == 1) ? 113 : 107);
  endfunction

  function automatic int row_time(input int ew, input int ehb, input int em);
    return ew + 1 + kval(em) + ((ehb < 9) ? 9 : ehb);
  endfunction

  function automatic int frame_rows(input int eh, input int evb, input int ei);
    return (ei >= eh + evb + 2) ? ei + 1 : eh + evb + 2;
  endfunction

  task automatic set_cfg(input int a_h, input int a_w, input int a_hb, input int a_vb,
                         input int a_dk, input int a_i, input int a_dv);
    h = 12'(a_h); w = 12'(a_w); hb = 12'(a_hb); vb = 12'(a_vb);
    dk = 2'(a_dk); integ = 12'(a_i); dv = 6'(a_dv);
  endtask

  task automatic wait_fs();
    @(negedge clk);
    while (!fs) @(negedge clk);
  endtask

  task automatic settle();
    wait_fs();
    wait_fs();
  endtask

  task automatic measure(input int eh, input int ew, input int ehb, input int evb,
                         input int em, input int ei, input int ediv,
                         input bit swap, input string treq);
    int d, wpx, hpx, r, fvp, tot, t, fvh, lines, lvrun, npv, last_rise, lv_fall, pvlast, low;
    bit prev_lv;
    d = ediv + 2;
    wpx = ew + 1;
    hpx = kval(em) + ((ehb < 9) ? 9 : ehb);
    r = wpx + hpx;
    fvp = (eh + 1) * r - (hpx - 12);
    tot = frame_rows(eh, evb, ei) * r;
    wait_fs();
    if (swap) begin
      h = n_h; w = n_w; hb = n_hb; vb = n_vb; dk = n_dk; integ = n_integ; dv = n_dv;
    end
    t = 0; fvh = 0; lines = 0; lvrun = 0; npv = 0; last_rise = 0; lv_fall = 0; pvlast = 0;
    prev_lv = 0;
    while (fv) begin
      if (t == 1) chk_eq("R6", "start pulse width", int'(fs), 0);
      if (lv && !prev_lv) begin
        if (lines == 0) chk_eq("R5", "frame lead", t, 6 * d);
        else chk_eq("R3", "row period", t - last_rise, r * d);
        last_rise = t;
        lines++;
        lvrun = 0;
        npv = 0;
      end
      if (lv) begin
        lvrun++;
        if (pv) begin
          if (npv > 0) chk_eq("R1", "pixel spacing", t - pvlast, d);
          chk_eq("R10", "col_idx", int'(col_idx), npv);
          chk_eq("R10", "row_idx", int'(row_idx), lines - 1);
          pvlast = t;
          npv++;
        end
      end
      if (!lv && prev_lv) begin
        chk_eq("R2", "line width", lvrun, wpx * d);
        chk_eq("R10", "pixels per line", npv, wpx);
        lv_fall = t;
      end
      prev_lv = lv;
      fvh++;
      t++;
      @(negedge clk);
    end
    chk_eq("R5", "frame trail", t - lv_fall, 6 * d);
    chk_eq("R5", "frame high time", fvh, fvp * d);
    chk_eq("R2", "lines per frame", lines, eh + 1);
    if (!swap) begin
      low = 0;
      while (!fs) begin
        low++;
        @(negedge clk);
      end
      chk_eq(treq, "frame low time", low, (tot - fvp) * d);
      chk_eq(treq, "frame length", fvh + low, tot * d);
    end
  endtask

  task automatic reset_check(input int eh, input int ew, input int ehb, input int evb,
                             input int em, input int ei, input int ediv);
    int cnt, nb;
    @(negedge clk);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk_eq("R11", "line_valid in reset", int'(lv), 0);
    chk_eq("R11", "frame_valid in reset", int'(fv), 0);
    chk_eq("R11", "frame_start in reset", int'(fs), 0);
    chk_eq("R11", "pixel_valid in reset", int'(pv), 0);
    rst = 1'b0;
    nb = frame_rows(eh, evb, ei) - (eh + 1);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!fs);
    chk_eq("R11", "first start after reset", cnt,
           (nb * row_time(ew, ehb, em) - 6) * (ediv + 2));
  endtask

  initial begin
    set_cfg(3, 15, 9, 1, 0, 0, 0);
    n_h = 0; n_w = 0; n_hb = 0; n_vb = 0; n_dk = 0; n_integ = 0; n_dv = 0;
    reset_check(3, 15, 9, 1, 0, 0, 0);
    measure(3, 15, 9, 1, 0, 0, 0, 1'b0, "R7");

    set_cfg(3, 15, 20, 1, 1, 0, 1);
    settle();
    measure(3, 15, 20, 1, 1, 0, 1, 1'b0, "R7");

    set_cfg(2, 7, 12, 0, 3, 0, 2);
    settle();
    measure(2, 7, 12, 0, 3, 0, 2, 1'b0, "R3");

    // R4: hblank 2 acts as 9
    set_cfg(3, 15, 2, 1, 2, 0, 0);
    settle();
    measure(3, 15, 2, 1, 2, 0, 0, 1'b0, "R4");

    // R8: above, at and below the stretch threshold
    set_cfg(3, 15, 9, 1, 1, 10, 0);
    settle();
    measure(3, 15, 9, 1, 1, 10, 0, 1'b0, "R8");
    set_cfg(3, 15, 9, 1, 1, 6, 0);
    settle();
    measure(3, 15, 9, 1, 1, 6, 0, 1'b0, "R8");
    set_cfg(3, 15, 9, 1, 1, 5, 0);
    settle();
    measure(3, 15, 9, 1, 1, 5, 0, 1'b0, "R8");

    // R9: swap settings just after frame_start
    set_cfg(3, 15, 9, 1, 0, 0, 0);
    settle();
    n_h = 12'd3; n_w = 12'd31; n_hb = 12'd9; n_vb = 12'd1;
    n_dk = 2'd1; n_integ = 12'd0; n_dv = 6'd0;
    measure(3, 15, 9, 1, 0, 0, 0, 1'b1, "R9");
    measure(3, 31, 9, 1, 1, 0, 0, 1'b0, "R9");

    reset_check(3, 31, 9, 1, 1, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule